// File: doc/BRIEF.md
# Pre-computed Branch Outcome Unit

This unit gives a conditional branch its exact outcome at fetch time instead of a guess. Each architectural register is shadowed by the PC of the instruction that last wrote it and a count of how many table entries use it as a branch operand. A small fully associative table remembers branches that were once taken. For each one it keeps the comparison kind, the two source register numbers and the PCs of the two instructions that produced those operands. Whenever an operand register of a stored branch is rewritten, the unit evaluates that branch's condition again with the new value. A later lookup therefore returns a result that is already known rather than predicted.

The unit has three interfaces. The register-write port mirrors the register file write-back: register number, value and writer PC. The lookup port takes a branch PC and its two source register numbers, and answers one cycle later with a hit flag and the outcome. The resolve port reports the branch's actual outcome after execution, and a taken branch with no matching entry is allocated there. If a write, a lookup and a resolve all occur in the same cycle, the unit applies them in that order.

Top module: `pcb_unit`

## Requirements
- R1: After reset the table is empty and the register shadows are zero: `lk_hit` and `lk_taken` are 0 and every lookup misses until a branch has been allocated.
- R2: A write to register k (k not 0) records `wr_pc` as k's last-writer PC and `wr_data` as its value. Writes to register 0 change nothing: register 0 always reads as value 0 with last-writer PC 0.
- R3: A lookup hits when a valid entry has a tag equal to `lk_pc`, stored operand numbers equal to `lk_ra` and `lk_rb`, and stored producer PCs equal to the current last-writer PCs of those two registers. On a hit, `lk_taken` carries the stored outcome.
- R4: A lookup that misses reports `lk_hit` = 0 and `lk_taken` = 0 (not taken).
- R5: A resolve allocates an entry only when `rs_taken` is 1 and no entry matches the branch under the R3 rule. The new entry copies the operands' current last-writer PCs and stores outcome 1. A not-taken resolve leaves the table unchanged.
- R6: Free entries are filled first, lowest index first. In a full table, allocation replaces the least recently used entry, and both an allocation and a lookup hit make an entry the most recently used.
- R7: A write to a register that is an operand of one or more valid entries re-evaluates each of those entries with the new value and overwrites its stored outcome. Comparison kinds are `rs_op` 2'b00 equal, 2'b01 not equal, 2'b10 signed less than, 2'b11 signed greater or equal. Producer PCs are not changed by the re-evaluation.
- R8: Each register's reference count equals the number of operand slots of valid entries that name it. A branch using one register twice counts twice, so eviction decrements that count twice. Counts never go below zero or above twice the table depth, and a write to a register with a zero count triggers no re-evaluation.
- R9: A lookup sees a write made in the same cycle, both its last-writer PC and the outcomes re-evaluated by it. It does not see an allocation made by a resolve in the same cycle.
- R10: Lookup results appear in the cycle after `lk_en`. In cycles with no lookup in the previous cycle, `lk_hit` and `lk_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write valid |
| wr_reg | input | 5 | Register being written |
| wr_data | input | 32 | Value written |
| wr_pc | input | 32 | PC of the writing instruction |
| lk_en | input | 1 | Lookup valid |
| lk_pc | input | 32 | PC of the branch looked up |
| lk_ra | input | 5 | First source register of the looked-up branch |
| lk_rb | input | 5 | Second source register of the looked-up branch |
| rs_en | input | 1 | Resolve valid |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_op | input | 2 | Comparison kind of the resolved branch |
| rs_ra | input | 5 | First source register of the resolved branch |
| rs_rb | input | 5 | Second source register of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| lk_hit | output | 1 | Lookup found an exact entry (one cycle after `lk_en`) |
| lk_taken | output | 1 | Outcome of the hit entry, 0 on a miss |

## Verification
The hardest situation to reach is a full table under eviction pressure in which the victim shares operand registers with surviving entries, or names one register twice. Only then can a wrong reference count silently suppress a later re-evaluation. The stimulus draws branch PCs from a pool larger than the table and ties each branch to a fixed register pair taken from a small set of six registers. It also reuses a handful of writer PCs, so entries keep hitting, get re-evaluated and get evicted, while reference counts repeatedly rise and fall. Directed steps first fill the table past capacity with one refreshed survivor, then reinsert a branch on a register whose double-counted entry was evicted.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_NE  = 2'b01,
    CMP_LT  = 2'b10,
    CMP_GE  = 2'b11
  } cmp_kind_e;
endpackage

// File: rtl/pcb_cond.sv
`timescale 1ns/1ps
module pcb_cond #(
  parameter int XLEN = 32
) (
  input  pcb_pkg::cmp_kind_e op,
  input  logic [XLEN-1:0]    a,
  input  logic [XLEN-1:0]    b,
  output logic               taken
);
  always_comb begin
    unique case (op)
      pcb_pkg::CMP_EQ: taken = (a == b);
      pcb_pkg::CMP_NE: taken = (a != b);
      pcb_pkg::CMP_LT: taken = ($signed(a) <  $signed(b));
      default:         taken = ($signed(a) >= $signed(b));
    endcase
  end
endmodule

// File: rtl/pcb_regtab.sv
`timescale 1ns/1ps
module pcb_regtab #(
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8,
  localparam int REGW = $clog2(NREG),
  localparam int RCW  = $clog2(2*DEPTH+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_reg,
  input  logic [XLEN-1:0] wr_data,
  input  logic [PCW-1:0]  wr_pc,
  input  logic            ins_en,
  input  logic [REGW-1:0] ins_ra,
  input  logic [REGW-1:0] ins_rb,
  input  logic            ev_en,
  input  logic [REGW-1:0] ev_ra,
  input  logic [REGW-1:0] ev_rb,
  output logic [XLEN-1:0] val_nx  [NREG],
  output logic [PCW-1:0]  ldpc_nx [NREG],
  output logic [RCW-1:0]  rc_q    [NREG]
);
  localparam int RC_MAX = 2*DEPTH;

  logic [XLEN-1:0] val_q  [NREG];
  logic [PCW-1:0]  ldpc_q [NREG];
  logic [RCW-1:0]  rc_nx  [NREG];
  logic            wr_act;

  assign wr_act = wr_en && (wr_reg != '0);

  // post-write view, consumed by lookup, allocation and recompute
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      if (wr_act && wr_reg == REGW'(r)) begin
        val_nx[r]  = wr_data;
        ldpc_nx[r] = wr_pc;
      end else begin
        val_nx[r]  = val_q[r];
        ldpc_nx[r] = ldpc_q[r];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      logic [1:0]   inc;
      logic [1:0]   dec;
      logic [RCW:0] sum;
      inc = 2'(ins_en && ins_ra == REGW'(r)) + 2'(ins_en && ins_rb == REGW'(r));
      dec = 2'(ev_en && ev_ra == REGW'(r)) + 2'(ev_en && ev_rb == REGW'(r));
      sum = {1'b0, rc_q[r]} + (RCW+1)'(inc);
      if (sum < (RCW+1)'(dec))
        rc_nx[r] = '0;
      else if (sum - (RCW+1)'(dec) > (RCW+1)'(RC_MAX))
        rc_nx[r] = RCW'(RC_MAX);
      else
        rc_nx[r] = RCW'(sum - (RCW+1)'(dec));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        val_q[r]  <= '0;
        ldpc_q[r] <= '0;
        rc_q[r]   <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_act && wr_reg == REGW'(r)) begin
          val_q[r]  <= wr_data;
          ldpc_q[r] <= wr_pc;
        end
        rc_q[r] <= rc_nx[r];
      end
    end
  end
endmodule

// File: rtl/pcb_predtab.sv
`timescale 1ns/1ps
module pcb_predtab #(
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8,
  localparam int REGW = $clog2(NREG),
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REGW-1:0]  wr_reg,
  input  logic             wr_rc_nz,
  input  logic [XLEN-1:0]  val_nx  [NREG],
  input  logic [PCW-1:0]   ldpc_nx [NREG],
  input  logic             lk_en,
  input  logic [PCW-1:0]   lk_pc,
  input  logic [REGW-1:0]  lk_ra,
  input  logic [REGW-1:0]  lk_rb,
  input  logic             rs_en,
  input  logic [PCW-1:0]   rs_pc,
  input  logic [1:0]       rs_op,
  input  logic [REGW-1:0]  rs_ra,
  input  logic [REGW-1:0]  rs_rb,
  input  logic             rs_taken,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic             ins_en,
  output logic [REGW-1:0]  ins_ra,
  output logic [REGW-1:0]  ins_rb,
  output logic             ev_en,
  output logic [REGW-1:0]  ev_ra,
  output logic [REGW-1:0]  ev_rb,
  output logic [DEPTH-1:0] ent_valid,
  output logic [REGW-1:0]  ent_ra [DEPTH],
  output logic [REGW-1:0]  ent_rb [DEPTH]
);
  import pcb_pkg::*;

  logic [PCW-1:0]   tag_q [DEPTH];
  cmp_kind_e        op_q  [DEPTH];
  logic [PCW-1:0]   pc1_q [DEPTH];
  logic [PCW-1:0]   pc2_q [DEPTH];
  logic [IDXW-1:0]  age_q [DEPTH];
  logic [IDXW-1:0]  age_b [DEPTH];
  logic [IDXW-1:0]  age_c [DEPTH];
  logic [DEPTH-1:0] pred_q, pred_nx, eval, lk_m, rs_m;
  logic [IDXW-1:0]  lk_idx, vic;
  logic             lk_any, wr_act;

  assign wr_act = wr_en && (wr_reg != '0) && wr_rc_nz;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    pcb_cond #(.XLEN(XLEN)) u_cond (
      .op(op_q[e]), .a(val_nx[ent_ra[e]]), .b(val_nx[ent_rb[e]]), .taken(eval[e])
    );
    assign pred_nx[e] = (ent_valid[e] && wr_act &&
                         (ent_ra[e] == wr_reg || ent_rb[e] == wr_reg)) ? eval[e] : pred_q[e];
    assign lk_m[e] = ent_valid[e] && tag_q[e] == lk_pc && ent_ra[e] == lk_ra &&
                     ent_rb[e] == lk_rb && pc1_q[e] == ldpc_nx[lk_ra] && pc2_q[e] == ldpc_nx[lk_rb];
    assign rs_m[e] = ent_valid[e] && tag_q[e] == rs_pc && ent_ra[e] == rs_ra &&
                     ent_rb[e] == rs_rb && pc1_q[e] == ldpc_nx[rs_ra] && pc2_q[e] == ldpc_nx[rs_rb];
  end

  assign lk_any = |lk_m;
  assign ins_en = rs_en && rs_taken && !(|rs_m);
  assign ins_ra = rs_ra;
  assign ins_rb = rs_rb;
  assign ev_en  = ins_en && ent_valid[vic];
  assign ev_ra  = ent_ra[vic];
  assign ev_rb  = ent_rb[vic];

  always_comb begin
    lk_idx = '0;
    for (int e = 0; e < DEPTH; e++)
      if (lk_m[e]) lk_idx = IDXW'(e);
  end

  // lookup refresh first, then victim choice and allocation refresh
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      age_b[j] = age_q[j];
      if (lk_en && lk_any) begin
        if (IDXW'(j) == lk_idx)           age_b[j] = '0;
        else if (age_q[j] < age_q[lk_idx]) age_b[j] = age_q[j] + 1'b1;
      end
    end
    vic = '0;
    for (int j = 0; j < DEPTH; j++)
      if (age_b[j] == IDXW'(DEPTH-1)) vic = IDXW'(j);
    for (int j = DEPTH-1; j >= 0; j--)
      if (!ent_valid[j]) vic = IDXW'(j);
    for (int j = 0; j < DEPTH; j++) begin
      age_c[j] = age_b[j];
      if (ins_en) begin
        if (IDXW'(j) == vic)            age_c[j] = '0;
        else if (age_b[j] < age_b[vic]) age_c[j] = age_b[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      pred_q    <= '0;
      lk_hit    <= 1'b0;
      lk_taken  <= 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        tag_q[e]  <= '0;
        op_q[e]   <= CMP_EQ;
        ent_ra[e] <= '0;
        ent_rb[e] <= '0;
        pc1_q[e]  <= '0;
        pc2_q[e]  <= '0;
        age_q[e]  <= IDXW'(e);
      end
    end else begin
      lk_hit   <= lk_en && lk_any;
      lk_taken <= lk_en && |(lk_m & pred_nx);
      pred_q   <= pred_nx;
      for (int e = 0; e < DEPTH; e++) age_q[e] <= age_c[e];
      if (ins_en) begin
        ent_valid[vic] <= 1'b1;
        pred_q[vic]    <= 1'b1;
        tag_q[vic]     <= rs_pc;
        op_q[vic]      <= cmp_kind_e'(rs_op);
        ent_ra[vic]    <= rs_ra;
        ent_rb[vic]    <= rs_rb;
        pc1_q[vic]     <= ldpc_nx[rs_ra];
        pc2_q[vic]     <= ldpc_nx[rs_rb];
      end
    end
  end
endmodule

// File: rtl/pcb_unit.sv
`timescale 1ns/1ps
module pcb_unit #(
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8,
  localparam int REGW = $clog2(NREG),
  localparam int RCW  = $clog2(2*DEPTH+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_reg,
  input  logic [XLEN-1:0] wr_data,
  input  logic [PCW-1:0]  wr_pc,
  input  logic            lk_en,
  input  logic [PCW-1:0]  lk_pc,
  input  logic [REGW-1:0] lk_ra,
  input  logic [REGW-1:0] lk_rb,
  input  logic            rs_en,
  input  logic [PCW-1:0]  rs_pc,
  input  logic [1:0]      rs_op,
  input  logic [REGW-1:0] rs_ra,
  input  logic [REGW-1:0] rs_rb,
  input  logic            rs_taken,
  output logic            lk_hit,
  output logic            lk_taken
);
  logic [XLEN-1:0]  val_nx  [NREG];
  logic [PCW-1:0]   ldpc_nx [NREG];
  logic [RCW-1:0]   rc_q    [NREG];
  logic             ins_en, ev_en, wr_rc_nz;
  logic [REGW-1:0]  ins_ra, ins_rb, ev_ra, ev_rb;
  logic [DEPTH-1:0] ent_valid;
  logic [REGW-1:0]  ent_ra [DEPTH];
  logic [REGW-1:0]  ent_rb [DEPTH];

  assign wr_rc_nz = (rc_q[wr_reg] != '0);

  pcb_regtab #(.NREG(NREG), .XLEN(XLEN), .PCW(PCW), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .wr_pc(wr_pc), .ins_en(ins_en), .ins_ra(ins_ra), .ins_rb(ins_rb),
    .ev_en(ev_en), .ev_ra(ev_ra), .ev_rb(ev_rb),
    .val_nx(val_nx), .ldpc_nx(ldpc_nx), .rc_q(rc_q)
  );

  pcb_predtab #(.NREG(NREG), .XLEN(XLEN), .PCW(PCW), .DEPTH(DEPTH)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_rc_nz(wr_rc_nz),
    .val_nx(val_nx), .ldpc_nx(ldpc_nx),
    .lk_en(lk_en), .lk_pc(lk_pc), .lk_ra(lk_ra), .lk_rb(lk_rb),
    .rs_en(rs_en), .rs_pc(rs_pc), .rs_op(rs_op), .rs_ra(rs_ra), .rs_rb(rs_rb),
    .rs_taken(rs_taken), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .ins_en(ins_en), .ins_ra(ins_ra), .ins_rb(ins_rb),
    .ev_en(ev_en), .ev_ra(ev_ra), .ev_rb(ev_rb),
    .ent_valid(ent_valid), .ent_ra(ent_ra), .ent_rb(ent_rb)
  );
endmodule

// File: rtl/pcb_unit_chk.sv
`timescale 1ns/1ps
module pcb_unit_chk #(
  parameter int NREG  = 32,
  parameter int DEPTH = 8,
  localparam int REGW = $clog2(NREG),
  localparam int RCW  = $clog2(2*DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_en,
  input logic             lk_hit,
  input logic             lk_taken,
  input logic             rs_en,
  input logic             rs_taken,
  input logic             ins_en,
  input logic [DEPTH-1:0] ent_valid,
  input logic [REGW-1:0]  ent_ra [DEPTH],
  input logic [REGW-1:0]  ent_rb [DEPTH],
  input logic [RCW-1:0]   rc_q   [NREG]
);
  logic [RCW-1:0] ref_cnt [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      ref_cnt[r] = '0;
      for (int e = 0; e < DEPTH; e++) begin
        ref_cnt[r] = ref_cnt[r] + RCW'(ent_valid[e] && ent_ra[e] == REGW'(r))
                                + RCW'(ent_valid[e] && ent_rb[e] == REGW'(r));
      end
    end
  end

  AST_HIT_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_en)); // R10
  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit); // R4
  AST_ALLOC_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (rs_en && rs_taken)); // R5
  AST_NO_INVALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> ($countones(ent_valid) >= $past($countones(ent_valid)))); // R6
  AST_NOT_TAKEN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs_en || !rs_taken) |=> $stable(ent_valid)); // R5

  for (genvar r = 0; r < NREG; r++) begin : g_rc
    AST_RC_TRACKS_REFS: assert property (@(posedge clk) disable iff (!rst_n)
      rc_q[r] == ref_cnt[r]); // R8
    AST_RC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      rc_q[r] <= RCW'(2*DEPTH)); // R8
  end
endmodule

bind pcb_unit pcb_unit_chk #(.NREG(NREG), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_hit(lk_hit), .lk_taken(lk_taken),
  .rs_en(rs_en), .rs_taken(rs_taken), .ins_en(ins_en), .ent_valid(ent_valid),
  .ent_ra(ent_ra), .ent_rb(ent_rb), .rc_q(rc_q)
);

// File: tb/sim_pcb_unit.sv
`timescale 1ns/1ps
module sim_pcb_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, lk_en, rs_en, rs_taken;
  logic [4:0]  wr_reg, lk_ra, lk_rb, rs_ra, rs_rb;
  logic [31:0] wr_data, wr_pc, lk_pc, rs_pc;
  logic [1:0]  rs_op;
  logic        lk_hit, lk_taken;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcb_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
    .wr_pc(wr_pc), .lk_en(lk_en), .lk_pc(lk_pc), .lk_ra(lk_ra), .lk_rb(lk_rb),
    .rs_en(rs_en), .rs_pc(rs_pc), .rs_op(rs_op), .rs_ra(rs_ra), .rs_rb(rs_rb),
    .rs_taken(rs_taken), .lk_hit(lk_hit), .lk_taken(lk_taken)
  );

  // reference state, built from the requirements
  logic [31:0] m_val [32];
  logic [31:0] m_ldpc [32];
  bit          e_v [8];
  logic [31:0] e_tag [8], e_p1 [8], e_p2 [8];
  logic [1:0]  e_op [8];
  logic [4:0]  e_ra [8], e_rb [8];
  bit          e_pred [8];
  longint      e_use [8];
  longint      tick = 0;

  function automatic bit cmp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'b00: return a == b;
      2'b01: return a != b;
      2'b10: return $signed(a) < $signed(b);
      default: return $signed(a) >= $signed(b);
    endcase
  endfunction

  function automatic int find(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b);
    for (int e = 0; e < 8; e++)
      if (e_v[e] && e_tag[e] == pc && e_ra[e] == a && e_rb[e] == b &&
          e_p1[e] == m_ldpc[a] && e_p2[e] == m_ldpc[b]) return e;
    return -1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input logic [4:0] wr, input logic [31:0] wd, input logic [31:0] wpc,
                      input bit le, input logic [31:0] lpc, input logic [4:0] la, input logic [4:0] lb,
                      input bit re, input logic [31:0] rpc, input logic [1:0] rop,
                      input logic [4:0] ra, input logic [4:0] rb, input bit rt, input string req);
    bit eh, et;
    int k;
    wr_en = we; wr_reg = wr; wr_data = wd; wr_pc = wpc;
    lk_en = le; lk_pc = lpc; lk_ra = la; lk_rb = lb;
    rs_en = re; rs_pc = rpc; rs_op = rop; rs_ra = ra; rs_rb = rb; rs_taken = rt;
    if (we && wr != 0) begin
      m_val[wr] = wd; m_ldpc[wr] = wpc;
      for (int e = 0; e < 8; e++)
        if (e_v[e] && (e_ra[e] == wr || e_rb[e] == wr))
          e_pred[e] = cmp(e_op[e], m_val[e_ra[e]], m_val[e_rb[e]]);
    end
    eh = 0; et = 0;
    if (le) begin
      k = find(lpc, la, lb);
      if (k >= 0) begin eh = 1; et = e_pred[k]; e_use[k] = 2*tick; end
    end
    if (re && rt && find(rpc, ra, rb) < 0) begin
      k = -1;
      for (int e = 7; e >= 0; e--) if (!e_v[e]) k = e;
      if (k < 0) begin
        k = 0;
        for (int e = 1; e < 8; e++) if (e_use[e] < e_use[k]) k = e;
      end
      e_v[k] = 1; e_tag[k] = rpc; e_op[k] = rop; e_ra[k] = ra; e_rb[k] = rb;
      e_p1[k] = m_ldpc[ra]; e_p2[k] = m_ldpc[rb]; e_pred[k] = 1; e_use[k] = 2*tick + 1;
    end
    tick++;
    @(posedge clk);
    @(negedge clk);
    check(req, lk_hit, eh, "lk_hit");
    check(req, lk_taken, et, "lk_taken");
  endtask

  task automatic wr_(input logic [4:0] r, input logic [31:0] d, input logic [31:0] pc, input string req);
    step(1, r, d, pc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic lk_(input logic [31:0] pc, input logic [4:0] a, input logic [4:0] b, input string req);
    step(0, 0, 0, 0, 1, pc, a, b, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic rs_(input logic [31:0] pc, input logic [1:0] op, input logic [4:0] a,
                     input logic [4:0] b, input bit t, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, pc, op, a, b, t, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234_5678);
    for (int r = 0; r < 32; r++) begin m_val[r] = 0; m_ldpc[r] = 0; end
    for (int e = 0; e < 8; e++) begin e_v[e] = 0; e_pred[e] = 0; e_use[e] = 0; end
    {wr_en, lk_en, rs_en, rs_taken} = '0;
    {wr_reg, lk_ra, lk_rb, rs_ra, rs_rb, rs_op} = '0;
    {wr_data, wr_pc, lk_pc, rs_pc} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", lk_hit, 1'b0, "lk_hit in reset");
    check("R1", lk_taken, 1'b0, "lk_taken in reset");
    rst_n = 1'b1;
    @(negedge clk);
    lk_("h40", 1, 2, "R1");
    // first encounter not taken: nothing allocated
    wr_(1, 5, 32'h10, "R2");
    wr_(2, 5, 32'h14, "R2");
    rs_(32'h40, 2'b00, 1, 2, 0, "R5");
    lk_(32'h40, 1, 2, "R5");
    rs_(32'h40, 2'b00, 1, 2, 1, "R5");
    lk_(32'h40, 1, 2, "R3");
    lk_(32'h40, 1, 3, "R4");
    // recompute by the same producer
    wr_(1, 7, 32'h10, "R7");
    lk_(32'h40, 1, 2, "R7");
    wr_(1, 7, 32'h20, "R3");
    lk_(32'h40, 1, 2, "R3");
    wr_(1, 5, 32'h10, "R7");
    lk_(32'h40, 1, 2, "R7");
    // same-cycle write and lookup
    step(1, 1, 9, 32'h10, 1, 32'h40, 1, 2, 0, 0, 0, 0, 0, 0, "R9");
    // same-cycle resolve allocation is invisible to the lookup
    step(0, 0, 0, 0, 1, 32'h44, 3, 3, 1, 32'h44, 2'b00, 3, 3, 1, "R9");
    lk_(32'h44, 3, 3, "R9");
    // register 0 writes are ignored
    wr_(3, 0, 32'h30, "R2");
    rs_(32'h48, 2'b11, 0, 3, 1, "R5");
    wr_(0, 32'h55, 32'h99, "R2");
    lk_(32'h48, 0, 3, "R2");
    wr_(3, 1, 32'h30, "R7");
    lk_(32'h48, 0, 3, "R7");
    // double-referenced register, then overflow the table
    wr_(4, 2, 32'h60, "R8");
    rs_(32'h4c, 2'b01, 4, 4, 1, "R8");
    for (int i = 0; i < 9; i++) begin
      rs_(32'h200 + 4*i, 2'b00, 6, 6, 1, "R6");
      lk_(32'h40, 1, 2, "R6");
    end
    lk_(32'h4c, 4, 4, "R6");
    lk_(32'h44, 3, 3, "R6");
    lk_(32'h200, 6, 6, "R6");
    lk_(32'h220, 6, 6, "R6");
    wr_(5, 3, 32'h64, "R8");
    rs_(32'h50, 2'b10, 4, 5, 1, "R8");
    wr_(4, 9, 32'h60, "R8");
    lk_(32'h50, 4, 5, "R8");
    wr_(4, 1, 32'h60, "R8");
    lk_(32'h50, 4, 5, "R8");
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int b;
      logic [4:0] a, c;
      logic [1:0] op;
      bit we, le, re;
      b  = $urandom_range(11);
      a  = 5'(b % 6);
      c  = 5'((b * 5 + 1) % 6);
      op = 2'(b % 4);
      we = ($urandom_range(2) != 0);
      le = ($urandom_range(1) != 0);
      re = ($urandom_range(2) == 0);
      begin
        logic [4:0]  wr;
        logic [31:0] wd, wp, rpc;
        logic [4:0]  ra, rb;
        logic [1:0]  rop;
        int bb;
        wr  = 5'($urandom_range(5));
        wd  = 32'($signed($urandom_range(4)) - 2);
        wp  = 32'h100 + 4 * $urandom_range(3);
        bb  = $urandom_range(11);
        ra  = 5'(bb % 6);
        rb  = 5'((bb * 5 + 1) % 6);
        rop = 2'(bb % 4);
        rpc = 32'h800 + 4 * bb;
        begin
          logic [31:0] va, vb;
          va = (we && wr != 0 && wr == ra) ? wd : m_val[ra];
          vb = (we && wr != 0 && wr == rb) ? wd : m_val[rb];
          step(we, wr, wd, wp, le, 32'h800 + 4 * b, a, c,
               re, rpc, rop, ra, rb, cmp(rop, va, vb), op == 2'b11 ? "R7" : "R3");
        end
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule